// File: doc/BRIEF.md
# Word Watch Flag Store

This block keeps two monitoring bits for every word of every line in a small directly indexed line array. One bit arms read monitoring and the other arms write monitoring. A lookup port takes a word address and whether the access is a load or a store. One cycle later it returns the word's two bits and a trigger indication, which marks an access that must be handed to the monitoring machinery.

Flags are armed and disarmed per line under a word mask. When a line that carries any armed bit is evicted, its bits move into a small fully associative victim table, keyed by line address. When that line is filled again, the saved bits are OR-ed with the bits requested by the fill, and the victim entry is released. A fill issued on behalf of a watch request is kept at the second level only. Only an ordinary fill produces the signal that allows a first-level install.

Top module: `wwf_watch_store`

## Requirements
- R1: After a synchronous reset every flag in the array is zero, the victim table is empty, and all outputs (`lk_ok`, `lk_rflag`, `lk_wflag`, `lk_trig`, `evict_ovf`, `fill_l1`) are zero.
- R2: A lookup with `lk_valid` high returns, on the next cycle, `lk_ok`=1 together with the read flag (bit 2w of the line's flag vector) and the write flag (bit 2w+1) of word w. Here `lk_addr` = {line, word}. A lookup in the same cycle as a command sees the flags as they were before that command. Without a lookup, all four lookup outputs are 0.
- R3: `lk_trig` is 1 for a load (`lk_store`=0) to a word whose read flag is set, or for a store (`lk_store`=1) to a word whose write flag is set, and is 0 otherwise.
- R4: The set command (`cmd_op`=0) ORs `cmd_rd` into the read flag and `cmd_wr` into the write flag of every word whose `cmd_wmask` bit is 1. Other words and bits keep their values.
- R5: The clear command (`cmd_op`=1) clears only the read flags (if `cmd_rd`) and the write flags (if `cmd_wr`) of the masked words. Every other bit is left unchanged.
- R6: An eviction (`cmd_op`=3) of a line with any flag set stores its flags in the victim table and zeroes the line. An eviction of a line with no flags stores nothing.
- R7: A fill (`cmd_op`=2) installs the requested bits (mask, `cmd_rd`, `cmd_wr`) OR-ed with any flags saved for that line. The saved entry is then released, so a later fill of the same line without another eviction installs only its own requested bits.
- R8: An eviction of a flagged line that is not already in the table, while the table is full, pulses `evict_ovf` on the next cycle and leaves the line's flags in the array. An eviction of a line already present in the table ORs its flags into that entry without overflow.
- R9: A fill with `cmd_watch`=0 pulses `fill_l1` on the next cycle. A fill with `cmd_watch`=1 (a watch request) never raises `fill_l1`.
- R10: `cmd_op` encodes set=0, clear=1, fill=2, evict=3. Nothing changes when `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (set, clear, fill, evict) |
| cmd_line | input | LA_W | Line address of the command |
| cmd_wmask | input | WORDS | Words affected by the command |
| cmd_rd | input | 1 | Command acts on read flags |
| cmd_wr | input | 1 | Command acts on write flags |
| cmd_watch | input | 1 | Fill is a watch request (second level only) |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | LA_W+log2(WORDS) | Word address {line, word} |
| lk_store | input | 1 | Lookup access is a store |
| lk_ok | output | 1 | Lookup result valid |
| lk_rflag | output | 1 | Read flag of the looked-up word |
| lk_wflag | output | 1 | Write flag of the looked-up word |
| lk_trig | output | 1 | Access is a triggering access |
| evict_ovf | output | 1 | Eviction refused because the victim table is full |
| fill_l1 | output | 1 | Ordinary fill may also install at the first level |

## Verification
The assertions assume that `cmd_op` only carries the four defined codes while `cmd_valid` is high. They also assume that reset is held for at least one clock before any command, and that lookups may arrive in any cycle, including cycles that carry a command. The stimulus drives only legal codes and mixes directed scenarios (filling the victim table to capacity, re-evicting a line already present, refill after release) with a long stretch of pseudo-random commands and lookups. The random traffic is confined to a few lines, so victim hits, merges and overflows recur often.

// File: rtl/wwf_pkg.sv
package wwf_pkg;
  typedef enum logic [1:0] {
    OP_SET   = 2'd0,
    OP_CLR   = 2'd1,
    OP_FILL  = 2'd2,
    OP_EVICT = 2'd3
  } wwf_op_e;
endpackage

// File: rtl/wwf_line_array.sv
module wwf_line_array #(
  parameter int LA_W = 4,
  parameter int FW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [LA_W-1:0] widx,
  input  logic [FW-1:0]   wdata,
  input  logic [LA_W-1:0] ridx_a,
  input  logic [LA_W-1:0] ridx_b,
  output logic [FW-1:0]   rdata_a,
  output logic [FW-1:0]   rdata_b
);
  localparam int LINES = 1 << LA_W;

  logic [FW-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/wwf_victim_table.sv
module wwf_victim_table #(
  parameter int DEPTH = 4,
  parameter int LA_W  = 4,
  parameter int FW    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LA_W-1:0] key,
  input  logic            ins_en,
  input  logic [FW-1:0]   ins_flags,
  input  logic            inv_en,
  output logic            hit,
  output logic [FW-1:0]   hit_flags,
  output logic            full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  logic [LA_W-1:0]  tag [DEPTH];
  logic [FW-1:0]    flg [DEPTH];
  logic [DEPTH-1:0] match;
  logic [IW-1:0]    hit_idx;
  logic [IW-1:0]    free_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag[g] == key);
  end

  always_comb begin
    hit       = |match;
    full      = &vld;
    hit_idx   = '0;
    free_idx  = '0;
    hit_flags = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_idx   = IW'(i);
        hit_flags = flg[i];
      end
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag[i] <= '0;
        flg[i] <= '0;
      end
    end else begin
      if (ins_en) begin
        if (hit) begin
          flg[hit_idx] <= flg[hit_idx] | ins_flags;
        end else if (!full) begin
          vld[free_idx] <= 1'b1;
          tag[free_idx] <= key;
          flg[free_idx] <= ins_flags;
        end
      end
      if (inv_en && hit) vld[hit_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/wwf_watch_store.sv
module wwf_watch_store #(
  parameter int LA_W     = 4,
  parameter int WORDS    = 4,
  parameter int VT_DEPTH = 4,
  localparam int WA_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int AW      = LA_W + WA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [LA_W-1:0]  cmd_line,
  input  logic [WORDS-1:0] cmd_wmask,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_watch,
  input  logic             lk_valid,
  input  logic [AW-1:0]    lk_addr,
  input  logic             lk_store,
  output logic             lk_ok,
  output logic             lk_rflag,
  output logic             lk_wflag,
  output logic             lk_trig,
  output logic             evict_ovf,
  output logic             fill_l1
);
  import wwf_pkg::*;

  localparam int FW = 2 * WORDS;

  wwf_op_e        op;
  logic [FW-1:0]  req_bits;
  logic [FW-1:0]  cur_flags;
  logic [FW-1:0]  lk_flags;
  logic [FW-1:0]  lk_shift;
  logic [FW-1:0]  wdata;
  logic           we;
  logic           vt_ins;
  logic           vt_inv;
  logic           vt_hit;
  logic           vt_full;
  logic [FW-1:0]  vt_flags;
  logic           ovf_now;
  logic [LA_W-1:0] lk_line;
  logic [WA_W-1:0] lk_word;

  assign op      = wwf_op_e'(cmd_op);
  assign lk_line = lk_addr[AW-1:WA_W];
  assign lk_word = lk_addr[WA_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_req
    assign req_bits[2*w]   = cmd_wmask[w] & cmd_rd;
    assign req_bits[2*w+1] = cmd_wmask[w] & cmd_wr;
  end

  wwf_line_array #(.LA_W(LA_W), .FW(FW)) u_array (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .widx    (cmd_line),
    .wdata   (wdata),
    .ridx_a  (cmd_line),
    .ridx_b  (lk_line),
    .rdata_a (cur_flags),
    .rdata_b (lk_flags)
  );

  wwf_victim_table #(.DEPTH(VT_DEPTH), .LA_W(LA_W), .FW(FW)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .key       (cmd_line),
    .ins_en    (vt_ins),
    .ins_flags (cur_flags),
    .inv_en    (vt_inv),
    .hit       (vt_hit),
    .hit_flags (vt_flags),
    .full      (vt_full)
  );

  always_comb begin
    we      = 1'b0;
    wdata   = cur_flags;
    vt_ins  = 1'b0;
    vt_inv  = 1'b0;
    ovf_now = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_SET: begin
          we    = 1'b1;
          wdata = cur_flags | req_bits;
        end
        OP_CLR: begin
          we    = 1'b1;
          wdata = cur_flags & ~req_bits;
        end
        OP_FILL: begin
          we     = 1'b1;
          wdata  = req_bits | (vt_hit ? vt_flags : '0);
          vt_inv = vt_hit;
        end
        OP_EVICT: begin
          if (cur_flags != '0) begin
            if (vt_hit || !vt_full) begin
              vt_ins = 1'b1;
              we     = 1'b1;
              wdata  = '0;
            end else begin
              ovf_now = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign lk_shift = lk_flags >> {lk_word, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_ok     <= 1'b0;
      lk_rflag  <= 1'b0;
      lk_wflag  <= 1'b0;
      lk_trig   <= 1'b0;
      evict_ovf <= 1'b0;
      fill_l1   <= 1'b0;
    end else begin
      lk_ok     <= lk_valid;
      lk_rflag  <= lk_valid & lk_shift[0];
      lk_wflag  <= lk_valid & lk_shift[1];
      lk_trig   <= lk_valid & (lk_store ? lk_shift[1] : lk_shift[0]);
      evict_ovf <= ovf_now;
      fill_l1   <= cmd_valid && (op == OP_FILL) && !cmd_watch;
    end
  end
endmodule

// File: rtl/wwf_watch_store_chk.sv
module wwf_watch_store_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_watch,
  input logic       vt_full,
  input logic       lk_valid,
  input logic       lk_ok,
  input logic       lk_rflag,
  input logic       lk_wflag,
  input logic       lk_trig,
  input logic       evict_ovf,
  input logic       fill_l1
);
  AST_LK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_ok); // R2
  AST_LK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_ok && !lk_rflag && !lk_wflag && !lk_trig); // R2
  AST_TRIG_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    lk_trig |-> (lk_rflag || lk_wflag)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    evict_ovf |-> $past(cmd_valid && cmd_op == 2'd3 && vt_full)); // R8
  AST_NO_L1_ON_WATCH: assert property (@(posedge clk) disable iff (rst)
    fill_l1 |-> $past(cmd_valid && cmd_op == 2'd2 && !cmd_watch)); // R9
endmodule

bind wwf_watch_store wwf_watch_store_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_watch (cmd_watch),
  .vt_full   (vt_full),
  .lk_valid  (lk_valid),
  .lk_ok     (lk_ok),
  .lk_rflag  (lk_rflag),
  .lk_wflag  (lk_wflag),
  .lk_trig   (lk_trig),
  .evict_ovf (evict_ovf),
  .fill_l1   (fill_l1)
);

// File: tb/test_wwf_watch_store.sv
module test_wwf_watch_store;
  localparam int LA_W = 4;
  localparam int WORDS = 4;
  localparam int VT_DEPTH = 4;
  localparam int AW = LA_W + 2;
  localparam int LINES = 1 << LA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [LA_W-1:0] cmd_line = '0;
  logic [WORDS-1:0] cmd_wmask = '0;
  logic cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_watch = 1'b0;
  logic lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_store = 1'b0;
  logic lk_ok, lk_rflag, lk_wflag, lk_trig, evict_ovf, fill_l1;

  always #5 clk = ~clk;

  wwf_watch_store #(.LA_W(LA_W), .WORDS(WORDS), .VT_DEPTH(VT_DEPTH)) i_wwf_watch_store (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
    .cmd_wmask(cmd_wmask), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_watch(cmd_watch),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_store(lk_store), .lk_ok(lk_ok),
    .lk_rflag(lk_rflag), .lk_wflag(lk_wflag), .lk_trig(lk_trig),
    .evict_ovf(evict_ovf), .fill_l1(fill_l1)
  );

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model
  logic [2*WORDS-1:0] mflags [LINES];
  int                 vq_line [$];
  logic [2*WORDS-1:0] vq_flags [$];
  logic e_ok = 0, e_r = 0, e_w = 0, e_t = 0, e_ovf = 0, e_l1 = 0;

  always @(posedge clk) begin
    logic [2*WORDS-1:0] nb, cur, f;
    int l, wd, hit;
    if (rst) begin
      for (int i = 0; i < LINES; i++) mflags[i] = '0;
      vq_line.delete();
      vq_flags.delete();
      {e_ok, e_r, e_w, e_t, e_ovf, e_l1} = '0;
    end else begin
      l  = int'(lk_addr) / WORDS;
      wd = int'(lk_addr) % WORDS;
      f  = mflags[l];
      e_ok = lk_valid;
      e_r  = lk_valid && f[2*wd];
      e_w  = lk_valid && f[2*wd+1];
      e_t  = lk_valid && (lk_store ? f[2*wd+1] : f[2*wd]);
      e_ovf = 0;
      e_l1  = 0;
      if (cmd_valid) begin
        for (int w = 0; w < WORDS; w++) begin
          nb[2*w]   = cmd_wmask[w] && cmd_rd;
          nb[2*w+1] = cmd_wmask[w] && cmd_wr;
        end
        cur = mflags[cmd_line];
        hit = -1;
        for (int i = 0; i < vq_line.size(); i++)
          if (vq_line[i] == int'(cmd_line)) hit = i;
        case (cmd_op)
          2'd0: mflags[cmd_line] = cur | nb;
          2'd1: mflags[cmd_line] = cur & ~nb;
          2'd2: begin
            if (hit >= 0) begin
              nb = nb | vq_flags[hit];
              vq_line.delete(hit);
              vq_flags.delete(hit);
            end
            mflags[cmd_line] = nb;
            e_l1 = !cmd_watch;
          end
          default: begin
            if (cur != 0) begin
              if (hit >= 0) begin
                vq_flags[hit] = vq_flags[hit] | cur;
                mflags[cmd_line] = '0;
              end else if (vq_line.size() < VT_DEPTH) begin
                vq_line.push_back(int'(cmd_line));
                vq_flags.push_back(cur);
                mflags[cmd_line] = '0;
              end else begin
                e_ovf = 1;
              end
            end
          end
        endcase
      end
    end
  end

  task automatic cmp(string what, logic act, logic exp, string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("lk_ok", lk_ok, e_ok, cur_req);
      cmp("lk_rflag", lk_rflag, e_r, cur_req);
      cmp("lk_wflag", lk_wflag, e_w, cur_req);
      cmp("lk_trig", lk_trig, e_t, (cur_req == "R1") ? "R1" : "R3");
      cmp("evict_ovf", evict_ovf, e_ovf, (cur_req == "R1") ? "R1" : "R8");
      cmp("fill_l1", fill_l1, e_l1, (cur_req == "R1") ? "R1" : "R9");
    end
  end

  task automatic step(bit cv, logic [1:0] op, int line, logic [WORDS-1:0] m,
                      bit rd, bit wr, bit watch, bit lv, int addr, bit st);
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_line = LA_W'(line); cmd_wmask = m;
    cmd_rd = rd; cmd_wr = wr; cmd_watch = watch;
    lk_valid = lv; lk_addr = AW'(addr); lk_store = st;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cmd(logic [1:0] op, int line, logic [WORDS-1:0] m, bit rd, bit wr, bit watch);
    step(1, op, line, m, rd, wr, watch, 0, 0, 0);
  endtask

  task automatic probe(int line);
    for (int w = 0; w < WORDS; w++) begin
      step(0, 0, 0, 0, 0, 0, 0, 1, line * WORDS + w, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1, line * WORDS + w, 1);
    end
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    for (int l = 0; l < LINES; l++) probe(l);

    cur_req = "R4";
    cmd(0, 3, 4'b0101, 1, 0, 0);
    cmd(0, 3, 4'b0011, 0, 1, 0);
    idle();
    probe(3);

    cur_req = "R5";
    cmd(1, 3, 4'b0001, 1, 0, 0);
    idle();
    probe(3);

    cur_req = "R2";  // command and lookup in the same cycle: old value seen
    step(1, 0, 3, 4'b1111, 1, 1, 0, 1, 3 * WORDS + 3, 0);
    idle();
    probe(3);

    cur_req = "R6";
    cmd(3, 3, 4'b0000, 0, 0, 0);
    cmd(3, 5, 4'b0000, 0, 0, 0);
    idle();
    probe(3);
    probe(5);

    cur_req = "R7";
    cmd(2, 3, 4'b1000, 0, 1, 1);
    idle();
    probe(3);
    cmd(2, 3, 4'b0010, 1, 0, 1);
    idle();
    probe(3);

    cur_req = "R9";
    cmd(2, 7, 4'b0001, 1, 1, 0);
    cmd(2, 6, 4'b0000, 0, 0, 0);
    idle();
    probe(7);

    cur_req = "R8";
    for (int l = 8; l < 13; l++) cmd(0, l, 4'b1001, 1, 1, 0);
    for (int l = 8; l < 13; l++) cmd(3, l, 4'b0000, 0, 0, 0);
    idle();
    probe(12);
    cmd(0, 9, 4'b0100, 0, 1, 0);
    cmd(3, 9, 4'b0000, 0, 0, 0);
    cmd(2, 9, 4'b0000, 0, 0, 1);
    idle();
    probe(9);

    cur_req = "R10";  // random traffic on a few lines, cmd_valid toggling
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 1), 2'($urandom), 8 + $urandom_range(0, 7), 4'($urandom),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), (8 + $urandom_range(0, 7)) * WORDS + $urandom_range(0, 3),
           $urandom_range(0, 1));
    end
    idle();
    for (int l = 8; l < 16; l++) probe(l);

    cur_req = "R1";
    rst = 1'b1;
    idle();
    idle();
    rst = 1'b0;
    probe(9);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule